// File: doc/BRIEF.md
# Column-Sum Reuse Box Filter

This block computes a sliding 3-tall by 2-wide box sum over a raster stream of 8-bit pixels. Pixels arrive one per accepted cycle, left to right and top to bottom, with a qualifying valid. Two line buffers hold the two rows above the current one. Each accepted pixel therefore completes one vertical three-pixel column. The block adds up only that one new column per step. The column sum from the previous step is kept in a carry register and added to it, so the left column of the window is never stored or summed again.

The first pixel of every row only loads the carry register, so that no sum is ever formed across a row boundary. The first two rows of the stream only fill the line buffers. After that, every later row yields one sum per column from the second column onward. Each sum appears one cycle after the pixel that completes it. The input valid may drop at any time, and while it is low nothing advances.

Top module: `colsum_box_filter`

## Requirements
- R1: After reset, `sumValid` is low and stays low until the third row of the stream has reached its second pixel.
- R2: When pixel (r, c) is accepted with r >= 2 and c >= 1, `sumValid` is high in the following cycle and `sumData` equals the sum of the six pixels at rows r-2, r-1, r and columns c-1, c.
- R3: Pixels in the first two rows (rows 0 and 1) of the stream produce no output.
- R4: The pixel in column 0 of any row produces no output; it only primes the carried column sum.
- R5: Each row from row 2 onward yields exactly IMG_W-1 outputs, in increasing column order, and rows follow one another with no idle cycle needed between them.
- R6: A cycle with `pixValid` low advances no position and causes `sumValid` to be low in the following cycle; the results are unchanged by such stalls.
- R7: `sumData` is 11 bits wide and holds the exact sum for any pixel values, up to 1530 when all six pixels are 255.
- R8: The carried column sum from the last column of one row never contributes to an output of the next row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| pixValid | input | 1 | Pixel present this cycle |
| pixData | input | 8 | Unsigned pixel, raster order |
| sumValid | output | 1 | Window sum present this cycle |
| sumData | output | 11 | Six-pixel window sum |

## Verification
Rows are fed with a linear ramp, with all pixels at the maximum value, with a pattern that alternates between 0 and 255, and with pseudo-random values. The ramp shows whether the right columns are picked. The all-maximum rows probe the width of the sum. The alternating rows would expose a column sum carried across a row edge or shifted by one column. Random idle cycles, one long stall and back-to-back rows show that stalls change no result and that priming happens again on every row.

// File: rtl/boxsum_pkg.sv
package boxsum_pkg;
  typedef struct packed {
    logic advance;  // a pixel is consumed this cycle
    logic prime;    // column 0: load carried sum only
    logic emit;     // form and register a window sum
  } strobe_t;
endpackage

// File: rtl/boxsum_linebuf.sv
module boxsum_linebuf #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout
);
  logic [W-1:0] mem [DEPTH];

  // read-before-write: dout carries the value stored one row earlier
  assign dout = mem[addr];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= din;
  end
endmodule

// File: rtl/boxsum_ctrl.sv
module boxsum_ctrl
  import boxsum_pkg::*;
#(
  parameter int IMG_W = 16,
  localparam int COL_W = $clog2(IMG_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pixValid,
  output logic [COL_W-1:0] colIdx,
  output strobe_t          strobe
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(IMG_W - 1);

  logic [COL_W-1:0] colCnt;
  logic [1:0]       rowsFilled;  // saturates at 2

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colCnt     <= '0;
      rowsFilled <= '0;
    end else if (pixValid) begin
      if (colCnt == LAST_COL) begin
        colCnt <= '0;
        if (rowsFilled != 2'd2) rowsFilled <= rowsFilled + 2'd1;
      end else begin
        colCnt <= colCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.advance = pixValid;
    strobe.prime   = pixValid && (colCnt == '0);
    strobe.emit    = pixValid && (colCnt != '0) && (rowsFilled == 2'd2);
  end

  assign colIdx = colCnt;

  AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && colCnt == LAST_COL) |=> (colCnt == '0)); // R8

  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && colCnt != LAST_COL) |=> (colCnt == $past(colCnt) + 1'b1)); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> $stable(colCnt)); // R6

  AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    colCnt <= LAST_COL); // R5
endmodule

// File: rtl/boxsum_datapath.sv
module boxsum_datapath
  import boxsum_pkg::*;
#(
  parameter int IMG_W = 16,
  parameter int PIX_W = 8,
  parameter int ROWS  = 3,
  localparam int COL_W = $clog2(IMG_W),
  localparam int SUM_W = PIX_W + $clog2(2 * ROWS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [COL_W-1:0] colIdx,
  input  logic [PIX_W-1:0] pixData,
  output logic             sumValid,
  output logic [SUM_W-1:0] sumData
);
  localparam int MAX_SUM = 2 * ROWS * ((1 << PIX_W) - 1);

  // tap[0] = current row, tap[k] = row k lines above
  logic [PIX_W-1:0] tap [ROWS];
  assign tap[0] = pixData;

  for (genvar k = 0; k < ROWS - 1; k++) begin : g_line
    boxsum_linebuf #(.DEPTH(IMG_W), .W(PIX_W)) u_lb (
      .clk (clk),
      .we  (strobe.advance),
      .addr(colIdx),
      .din (tap[k]),
      .dout(tap[k+1])
    );
  end

  logic [SUM_W-1:0] colSum;
  logic [SUM_W-1:0] carrySum;

  always_comb begin
    colSum = '0;
    for (int k = 0; k < ROWS; k++) colSum = colSum + SUM_W'(tap[k]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      carrySum <= '0;
      sumValid <= 1'b0;
      sumData  <= '0;
    end else begin
      sumValid <= strobe.emit;
      if (strobe.advance) carrySum <= colSum;  // prime or reuse
      if (strobe.emit)    sumData  <= carrySum + colSum;
    end
  end

  AST_SUM_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    sumValid |-> (int'(sumData) <= MAX_SUM)); // R7

  AST_OUT_AFTER_IN: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |=> !sumValid); // R6

  AST_NO_PRIME_OUT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.prime |=> !sumValid); // R4
endmodule

// File: rtl/colsum_box_filter.sv
module colsum_box_filter
  import boxsum_pkg::*;
#(
  parameter int IMG_W = 16,
  localparam int PIX_W = 8,
  localparam int COL_W = $clog2(IMG_W),
  localparam int SUM_W = PIX_W + 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pixValid,
  input  logic [PIX_W-1:0] pixData,
  output logic             sumValid,
  output logic [SUM_W-1:0] sumData
);
  strobe_t          strobe;
  logic [COL_W-1:0] colIdx;

  boxsum_ctrl #(.IMG_W(IMG_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .pixValid(pixValid),
    .colIdx  (colIdx),
    .strobe  (strobe)
  );

  boxsum_datapath #(.IMG_W(IMG_W), .PIX_W(PIX_W), .ROWS(3)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .colIdx  (colIdx),
    .pixData (pixData),
    .sumValid(sumValid),
    .sumData (sumData)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> !sumValid); // R1
endmodule

// File: tb/sim_colsum_box_filter.sv
module sim_colsum_box_filter;
  localparam int W    = 10;
  localparam int NROW = 9;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pixValid = 1'b0;
  logic [7:0]  pixData = '0;
  logic        sumValid;
  logic [10:0] sumData;

  int total = 0;
  int bad = 0;
  int expQ[$];
  int expCount = 0;
  int gotCount = 0;
  bit finished = 1'b0;
  bit lastIn = 1'b0;
  int p2[W];
  int p1[W];
  int cur[W];

  always #10 clk = ~clk;  // 50 MHz

  colsum_box_filter #(.IMG_W(W)) u0 (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixData(pixData),
    .sumValid(sumValid), .sumData(sumData)
  );

  function automatic int genPix(int r, int c);
    case (r % 4)
      0: return (r * 17 + c * 23) % 256;       // ramp
      1: return 255;                            // max, R7
      2: return ((c + r) % 2) ? 255 : 0;        // alternating, R8
      default: return int'($urandom_range(255));
    endcase
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      pixValid = 1'b0;
      pixData  = 8'hxx;
    end
  endtask

  // driver: pushes expected sums (R2), none for rows 0-1 (R3) or column 0 (R4)
  task automatic sendRow(int r, bit stalls);
    for (int c = 0; c < W; c++) begin
      int v;
      if (stalls && ($urandom_range(3) == 0)) idle(int'($urandom_range(1, 3)));
      v = genPix(r, c);
      cur[c] = v;
      if (r >= 2 && c >= 1) begin
        expQ.push_back(p2[c-1] + p1[c-1] + cur[c-1] + p2[c] + p1[c] + v);
        expCount++;
      end
      @(posedge clk); #1;
      pixValid = 1'b1;
      pixData  = 8'(v);
    end
    for (int c = 0; c < W; c++) begin
      p2[c] = p1[c];
      p1[c] = cur[c];
    end
  endtask

  // monitor: outputs sampled at the falling edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (sumValid) begin
        gotCount++;
        total++;
        if (!lastIn) begin
          bad++;
          $display("FAIL R6: output without accepted pixel, got=%0d exp=none", sumData);
        end else if (expQ.size() == 0) begin
          bad++;
          $display("FAIL R3 or R4: unexpected output got=%0d exp=none", sumData);
        end else begin
          int e;
          e = expQ.pop_front();
          if (int'(sumData) != e) begin
            bad++;
            $display("FAIL R2: window sum got=%0d exp=%0d", sumData, e);
          end
        end
      end
    end
    lastIn = pixValid;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: got=timeout exp=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    total++;
    if (sumValid !== 1'b0) begin
      bad++;
      $display("FAIL R1: reset sumValid got=%b exp=0", sumValid);
    end
    // rows 0..3 back-to-back (R5), then stalls (R6)
    for (int r = 0; r < NROW; r++) begin
      sendRow(r, r >= 4);
      if (r == 6) idle(25);
    end
    idle(4);
    finished = 1'b1;
    total++;
    if (gotCount != expCount || expCount != (NROW - 2) * (W - 1)) begin
      bad++;
      $display("FAIL R5: output count got=%0d exp=%0d", gotCount, (NROW - 2) * (W - 1));
    end
    total++;
    if (expQ.size() != 0) begin
      bad++;
      $display("FAIL R2: missing outputs got=%0d exp=0", expQ.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule